// File: doc/BRIEF.md
# Parameter Table Walker

This block walks a calibration parameter table that lives in a byte-addressed, word-wide memory and pulls out the pin map of one parallel I/O interface. It is started with a one-cycle pulse that carries a 24-bit table base address and an 8-bit interface identifier. It then performs a chain of dependent reads over a simple request/valid read port, with only one read outstanding at any time.

First it reads the table size. Then it searches the interface pointer entries for the requested identifier. The search cannot rely on position, because merged tables place interface sections in no fixed order. It then follows the interface's group count, group descriptors and pin-list offsets. Each packed 16-bit pin descriptor is decoded and emitted on a descriptor stream, with a flag that tells a strobe pin from a data pin.

Every address the walker generates is bounded by the table size. A missing interface, an out-of-bound access or a malformed descriptor ends the walk with a one-cycle error pulse. A clean walk ends with a one-cycle done pulse.

Top module: `ptab_walker`

## Requirements
- R1: After reset, rd_req, busy, done, error and desc_valid are all 0.
- R2: Every read address is base_addr plus a byte offset. The first read of a walk goes to base+0x14, and bits [23:0] of that word are taken as the table size.
- R3: At most one read is outstanding. After rd_req is seen, no new rd_req appears until rd_valid has returned the data, which may take one or more cycles.
- R4: Pointer entries are read from consecutive words starting at base+0x18. Bits [31:24] of an entry are the interface ID and bits [23:0] are the section offset. The first entry whose ID equals target_id is used, wherever it sits in the list.
- R5: An all-zero pointer entry, or a next entry whose offset would exceed the table size, ends the search with error.
- R6: The group count is bits [7:0] of the word at base+ptr+0x4 and is shown on grp_count. Group g's descriptor is the word at base+ptr+0x8+8*g, with the pin count in bits [5:0] and the lane count in bits [7:6]. These counts are shown on grp_pins and grp_lanes while that group's descriptors stream.
- R7: The word at base+ptr+0xC+8*g gives, in bits [15:0], the offset from base of group g's pin list. Bits [31:16] of that word are not used.
- R8: Pin words are read from consecutive addresses. Each carries two 16-bit descriptors, bits [15:0] first, and each descriptor is lane [15:8], type [7:4], pin [3:0]. Exactly grp_pins descriptors are emitted per group, in list order, and the unused upper half of a final pin word is ignored.
- R9: Type 0xE marks a strobe pin (desc_strobe=1) and type 0xF marks a data pin (desc_strobe=0). Any other type ends the walk with error, and no descriptor is emitted for it.
- R10: No read is issued to an offset greater than the table size. Such an access ends the walk with error instead.
- R11: done and error are one-cycle pulses and never occur together. done comes in the cycle right after the last descriptor. A group count of 0 gives done with no descriptors.
- R12: A start pulse while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle walk request |
| base_addr | input | 24 | Table base address, captured on start |
| target_id | input | 8 | Interface ID to search for, captured on start |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | 24 | Read byte address, valid with rd_req |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk completed pulse |
| error | output | 1 | Walk failed pulse |
| grp_count | output | 8 | Number of groups of the found interface |
| grp_pins | output | 6 | Pins in the current group |
| grp_lanes | output | 2 | Lanes in the current group |
| desc_valid | output | 1 | Descriptor output strobe |
| desc_lane | output | 8 | Lane address of the descriptor |
| desc_pin | output | 4 | Pin index within the lane |
| desc_strobe | output | 1 | 1 for a strobe pin, 0 for a data pin |

## Verification
Every stage of the walk derives its next address from the data it has just read, so a wrong internal offset, pointer or group index appears on rd_addr at the very next request. The bench compares each request address against a behavioural table walk as it is issued. A miscounted pin index or a wrongly selected descriptor half shows up as a mismatched or extra descriptor in the cycle it is emitted, or as a done pulse that comes too early or too late. Error paths are checked by the absence of any request beyond the size bound, and by the arrival of the error pulse in place of done.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

  // Fixed table layout offsets (bytes).
  localparam int unsigned OFF_TABLE_SIZE = 32'h14;
  localparam int unsigned OFF_PTR_FIRST  = 32'h18;
  localparam int unsigned OFF_GROUP_CNT  = 32'h4;
  localparam int unsigned OFF_GROUP_DESC = 32'h8;
  localparam int unsigned GROUP_STRIDE   = 32'h8;
  localparam int unsigned WORD_BYTES     = 32'h4;

  // Pin descriptor layout.
  localparam int unsigned DESC_W      = 16;
  localparam logic [3:0]  KIND_STROBE = 4'hE;
  localparam logic [3:0]  KIND_DATA   = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SIZE,
    ST_PTR,
    ST_NGRP,
    ST_GDESC,
    ST_OFFS,
    ST_PIN,
    ST_HI,
    ST_DONE,
    ST_ERR
  } walk_st_e;

  typedef struct packed {
    logic [7:0] lane;
    logic [3:0] pin;
    logic       strobe;
    logic       ok;
  } pin_desc_t;

endpackage

// File: rtl/ptab_addr_gen.sv
module ptab_addr_gen #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] rel,
  input  logic [AW-1:0] limit,
  input  logic          check_en,
  output logic [AW-1:0] addr,
  output logic          oob
);

  always_comb begin
    addr = base + rel;
    oob  = check_en && (rel > limit);
  end

endmodule

// File: rtl/ptab_desc_decode.sv
module ptab_desc_decode
  import ptab_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output pin_desc_t         dec
);

  logic [3:0] kind;

  always_comb begin
    kind       = raw[7:4];
    dec.lane   = raw[15:8];
    dec.pin    = raw[3:0];
    dec.strobe = (kind == KIND_STROBE);
    dec.ok     = (kind == KIND_STROBE) || (kind == KIND_DATA);
  end

endmodule

// File: rtl/ptab_walker.sv
module ptab_walker
  import ptab_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int IDW   = 8,
  parameter int PINW  = 6,
  parameter int LANEW = 2,
  parameter int GCW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [IDW-1:0]   target_id,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [GCW-1:0]   grp_count,
  output logic [PINW-1:0]  grp_pins,
  output logic [LANEW-1:0] grp_lanes,
  output logic             desc_valid,
  output logic [7:0]       desc_lane,
  output logic [3:0]       desc_pin,
  output logic             desc_strobe
);

  localparam int ID_LSB  = DW - IDW;
  localparam int OFFW    = 16;
  localparam logic [AW-1:0] K_SIZE   = AW'(OFF_TABLE_SIZE);
  localparam logic [AW-1:0] K_PTR0   = AW'(OFF_PTR_FIRST);
  localparam logic [AW-1:0] K_NGRP   = AW'(OFF_GROUP_CNT);
  localparam logic [AW-1:0] K_GDESC  = AW'(OFF_GROUP_DESC);
  localparam logic [AW-1:0] K_STRIDE = AW'(GROUP_STRIDE);
  localparam logic [AW-1:0] K_WORD   = AW'(WORD_BYTES);

  walk_st_e st_q, st_d;
  logic [AW-1:0]     base_q, rel_q, rel_d, size_q, size_d;
  logic [AW-1:0]     ptr_q, ptr_d, gaddr_q, gaddr_d;
  logic [IDW-1:0]    tid_q;
  logic [GCW-1:0]    ngrp_q, ngrp_d, grp_q, grp_d;
  logic [PINW-1:0]   pins_q, pins_d, cnt_q, cnt_d;
  logic [LANEW-1:0]  lanes_q, lanes_d;
  logic [DESC_W-1:0] hi_q, hi_d;
  logic              pend_q, pend_d;
  logic              dv_q, dv_d, done_q, done_d, err_q, err_d;
  pin_desc_t         desc_q, desc_d;
  logic              cap_en, is_rd, oob, grp_last, pins_last;

  // Address generation and bound check against the table size.
  ptab_addr_gen #(.AW(AW)) u_addr (
    .base     (base_q),
    .rel      (rel_q),
    .limit    (size_q),
    .check_en (st_q != ST_SIZE),
    .addr     (rd_addr),
    .oob      (oob)
  );

  // Two descriptor decoders: lower half straight from the bus, upper half from the hold register.
  logic [DESC_W-1:0] half_raw [2];
  pin_desc_t         half_dec [2];
  assign half_raw[0] = rd_data[DESC_W-1:0];
  assign half_raw[1] = hi_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    ptab_desc_decode u_dec (
      .raw (half_raw[h]),
      .dec (half_dec[h])
    );
  end

  assign cap_en    = (st_q == ST_IDLE) && start;
  assign is_rd     = (st_q == ST_SIZE) || (st_q == ST_PTR) || (st_q == ST_NGRP) ||
                     (st_q == ST_GDESC) || (st_q == ST_OFFS) || (st_q == ST_PIN);
  assign rd_req    = is_rd && !pend_q && !oob;
  assign grp_last  = (grp_q + GCW'(1)) == ngrp_q;
  assign pins_last = (cnt_q + PINW'(1)) == pins_q;

  // Next-state logic.
  always_comb begin
    st_d    = st_q;
    rel_d   = rel_q;
    size_d  = size_q;
    ptr_d   = ptr_q;
    gaddr_d = gaddr_q;
    ngrp_d  = ngrp_q;
    grp_d   = grp_q;
    pins_d  = pins_q;
    lanes_d = lanes_q;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    pend_d  = pend_q;
    desc_d  = desc_q;
    dv_d    = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;

    if (is_rd) begin
      if (!pend_q) begin
        if (oob) st_d = ST_ERR;
        else     pend_d = 1'b1;
      end else if (rd_valid) begin
        pend_d = 1'b0;
        unique case (st_q)
          ST_SIZE: begin
            size_d = rd_data[AW-1:0];
            rel_d  = K_PTR0;
            st_d   = ST_PTR;
          end
          ST_PTR: begin
            if (rd_data == '0) begin
              st_d = ST_ERR;
            end else if (rd_data[DW-1 -: IDW] == tid_q) begin
              ptr_d = rd_data[AW-1:0];
              rel_d = rd_data[AW-1:0] + K_NGRP;
              st_d  = ST_NGRP;
            end else begin
              rel_d = rel_q + K_WORD;
            end
          end
          ST_NGRP: begin
            ngrp_d  = rd_data[GCW-1:0];
            grp_d   = '0;
            gaddr_d = ptr_q + K_GDESC;
            rel_d   = ptr_q + K_GDESC;
            st_d    = (rd_data[GCW-1:0] == '0) ? ST_DONE : ST_GDESC;
          end
          ST_GDESC: begin
            pins_d  = rd_data[PINW-1:0];
            lanes_d = rd_data[PINW +: LANEW];
            rel_d   = rel_q + K_WORD;
            st_d    = ST_OFFS;
          end
          ST_OFFS: begin
            rel_d = AW'(rd_data[OFFW-1:0]);
            cnt_d = '0;
            if (pins_q != '0) begin
              st_d = ST_PIN;
            end else if (grp_last) begin
              st_d = ST_DONE;
            end else begin
              grp_d   = grp_q + GCW'(1);
              gaddr_d = gaddr_q + K_STRIDE;
              rel_d   = gaddr_q + K_STRIDE;
              st_d    = ST_GDESC;
            end
          end
          ST_PIN: begin
            if (!half_dec[0].ok) begin
              st_d = ST_ERR;
            end else begin
              dv_d   = 1'b1;
              desc_d = half_dec[0];
              cnt_d  = cnt_q + PINW'(1);
              hi_d   = rd_data[2*DESC_W-1:DESC_W];
              if (!pins_last) begin
                st_d = ST_HI;
              end else if (grp_last) begin
                st_d = ST_DONE;
              end else begin
                grp_d   = grp_q + GCW'(1);
                gaddr_d = gaddr_q + K_STRIDE;
                rel_d   = gaddr_q + K_STRIDE;
                st_d    = ST_GDESC;
              end
            end
          end
          default: ;
        endcase
      end
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            rel_d  = K_SIZE;
            pend_d = 1'b0;
            st_d   = ST_SIZE;
          end
        end
        ST_HI: begin
          if (!half_dec[1].ok) begin
            st_d = ST_ERR;
          end else begin
            dv_d   = 1'b1;
            desc_d = half_dec[1];
            cnt_d  = cnt_q + PINW'(1);
            if (!pins_last) begin
              rel_d = rel_q + K_WORD;
              st_d  = ST_PIN;
            end else if (grp_last) begin
              st_d = ST_DONE;
            end else begin
              grp_d   = grp_q + GCW'(1);
              gaddr_d = gaddr_q + K_STRIDE;
              rel_d   = gaddr_q + K_STRIDE;
              st_d    = ST_GDESC;
            end
          end
        end
        ST_DONE: begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
        ST_ERR: begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Request capture, enabled only when idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tid_q  <= '0;
    end else if (cap_en) begin
      base_q <= base_addr;
      tid_q  <= target_id;
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rel_q   <= '0;
      size_q  <= '0;
      ptr_q   <= '0;
      gaddr_q <= '0;
      ngrp_q  <= '0;
      grp_q   <= '0;
      pins_q  <= '0;
      lanes_q <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
      pend_q  <= 1'b0;
      desc_q  <= '0;
      dv_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      rel_q   <= rel_d;
      size_q  <= size_d;
      ptr_q   <= ptr_d;
      gaddr_q <= gaddr_d;
      ngrp_q  <= ngrp_d;
      grp_q   <= grp_d;
      pins_q  <= pins_d;
      lanes_q <= lanes_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
      pend_q  <= pend_d;
      desc_q  <= desc_d;
      dv_q    <= dv_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign error       = err_q;
  assign grp_count   = ngrp_q;
  assign grp_pins    = pins_q;
  assign grp_lanes   = lanes_q;
  assign desc_valid  = dv_q;
  assign desc_lane   = desc_q.lane;
  assign desc_pin    = desc_q.pin;
  assign desc_strobe = desc_q.strobe;

  // R3: a request is never followed by another in the next cycle.
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R10: every request after the size read stays inside the table.
  a_r10_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && st_q != ST_SIZE) |-> ((rd_addr - base_q) <= size_q));

  // R11: done and error are single-cycle and exclusive.
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R12: captured request is held while a walk runs.
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q));

  // R8: never more descriptors than the group's pin count.
  a_r8_pin_count: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (cnt_q <= pins_q));

endmodule

// File: tb/ptab_walker_test.sv
module ptab_walker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] base_addr;
  logic [7:0]  target_id;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        busy, done, error;
  logic [7:0]  grp_count;
  logic [5:0]  grp_pins;
  logic [1:0]  grp_lanes;
  logic        desc_valid;
  logic [7:0]  desc_lane;
  logic [3:0]  desc_pin;
  logic        desc_strobe;

  always #4 clk = ~clk;

  ptab_walker uut (
    .clk, .rst_n, .start, .base_addr, .target_id, .rd_req, .rd_addr,
    .rd_valid, .rd_data, .busy, .done, .error, .grp_count, .grp_pins,
    .grp_lanes, .desc_valid, .desc_lane, .desc_pin, .desc_strobe
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [31:0] mem [0:255];
  int cur_base;
  int exp_addr[$];
  int exp_desc[$];
  int exp_end;
  int exp_ng;
  int seen_end;
  int last_desc_cyc;
  int nreads = 0;
  int prev_end = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] get(input int rel);
    if (rel >= 0 && rel < 1024) return mem[rel >> 2];
    return 32'h0;
  endfunction

  task automatic put(input int rel, input logic [31:0] v);
    mem[rel >> 2] = v;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  // Behavioural walk of the table: expected addresses, descriptors and outcome.
  task automatic ref_walk(input int tid);
    int rel, size, ptr, ng, np, nl, poff, gb, typ;
    logic [31:0] w;
    logic [15:0] half;
    exp_addr.delete(); exp_desc.delete(); exp_end = 1; exp_ng = -1;
    exp_addr.push_back(cur_base + 'h14);
    size = int'(get('h14) & 32'hFFFFFF);
    rel = 'h18;
    forever begin
      if (rel > size) begin exp_end = 2; return; end
      exp_addr.push_back(cur_base + rel);
      w = get(rel);
      if (w == 0) begin exp_end = 2; return; end
      if (int'(w[31:24]) == tid) begin ptr = int'(w[23:0]); break; end
      rel += 4;
    end
    rel = ptr + 4;
    if (rel > size) begin exp_end = 2; return; end
    exp_addr.push_back(cur_base + rel);
    ng = int'(get(rel) & 32'hFF);
    exp_ng = ng;
    w = 0;
    for (int g = 0; g < ng; g++) begin
      gb = ptr + 8 + 8 * g;
      if (gb > size) begin exp_end = 2; return; end
      exp_addr.push_back(cur_base + gb);
      np = int'(get(gb) & 32'h3F);
      nl = int'((get(gb) >> 6) & 32'h3);
      if (gb + 4 > size) begin exp_end = 2; return; end
      exp_addr.push_back(cur_base + gb + 4);
      poff = int'(get(gb + 4) & 32'hFFFF);
      for (int k = 0; k < np; k++) begin
        rel = poff + 4 * (k / 2);
        if (k % 2 == 0) begin
          if (rel > size) begin exp_end = 2; return; end
          exp_addr.push_back(cur_base + rel);
          w = get(rel);
        end
        half = (k % 2 == 0) ? w[15:0] : w[31:16];
        typ = int'(half[7:4]);
        if (typ != 'hE && typ != 'hF) begin exp_end = 2; return; end
        exp_desc.push_back((int'(half[15:8]) << 20) | (int'(half[3:0]) << 16) |
                           ((typ == 'hE ? 1 : 0) << 12) | (np << 4) | nl);
      end
    end
  endtask

  // Memory model: one request at a time, latency 1 to 3 cycles.
  initial begin
    rd_valid = 1'b0;
    rd_data  = 32'h0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rst_n === 1'b1 && rd_req) begin
        automatic int a = int'(rd_addr);
        automatic int lat = 1 + (nreads % 3);
        nreads++;
        if (exp_addr.size() == 0) chk(1'b0, "R10 unexpected read", a, 0);
        else begin
          automatic int e = exp_addr.pop_front();
          chk(a == e, "R2,R4,R6,R7,R10 read address", a, e);
        end
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(!rd_req, "R3 single outstanding read", int'(rd_req), 0);
        end
        rd_valid = 1'b1;
        rd_data  = get(a - cur_base);
      end
    end
  end

  // Per-clock comparison of the output stream against the reference.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (desc_valid) begin
          automatic int act = (int'(desc_lane) << 20) | (int'(desc_pin) << 16) |
                              (int'(desc_strobe) << 12) | (int'(grp_pins) << 4) | int'(grp_lanes);
          last_desc_cyc = cyc;
          if (exp_desc.size() == 0) chk(1'b0, "R8 extra descriptor", act, 0);
          else begin
            automatic int e = exp_desc.pop_front();
            chk(act == e, "R6,R8,R9 descriptor", act, e);
          end
        end
        if (done || error) begin
          automatic int ae = done ? 1 : 2;
          seen_end = 1;
          chk(!(done && error), "R11 done with error", 3, ae);
          chk(prev_end == 0, "R11 single-cycle pulse", prev_end, 0);
          chk(ae == exp_end, "R5,R9,R10,R11 outcome", ae, exp_end);
          if (done && exp_ng >= 0) chk(int'(grp_count) == exp_ng, "R6 group count", int'(grp_count), exp_ng);
          if (done && exp_ng > 0 && last_desc_cyc >= 0)
            chk(cyc == last_desc_cyc + 1, "R11 done timing", cyc, last_desc_cyc + 1);
        end
        prev_end = (done || error) ? 1 : 0;
      end
    end
  end

  task automatic run_begin(input int base, input int tid);
    cur_base = base;
    ref_walk(tid);
    seen_end = 0;
    last_desc_cyc = -1;
    @(negedge clk);
    base_addr = 24'(base);
    target_id = 8'(tid);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_wait(input string tag);
    int n = 0;
    while (!seen_end && n < 3000) begin
      @(negedge clk);
      #1;
      n++;
    end
    chk(seen_end != 0, {tag, " walk finished"}, n, 0);
    chk(exp_addr.size() == 0, {tag, " R2,R4,R7 all reads issued"}, exp_addr.size(), 0);
    chk(exp_desc.size() == 0, {tag, " R8 descriptor count"}, exp_desc.size(), 0);
    repeat (3) @(negedge clk);
    chk(!busy, {tag, " idle after walk"}, int'(busy), 0);
  endtask

  task automatic load_single(input int size_word, input logic [31:0] w5c);
    clear_mem();
    put('h14, 32'(size_word));
    put('h18, 32'h80000044);
    put('h48, 32'h00000001);
    put('h4C, 32'h00000045);
    put('h50, 32'h00540058);
    put('h58, 32'h00F100E0);
    put('h5C, w5c);
    put('h60, 32'hDEAD00F4);
  endtask

  task automatic load_merged();
    clear_mem();
    put('h14, 32'h000000C0);
    put('h18, 32'h81000040);
    put('h1C, 32'h80000080);
    put('h44, 32'h00000001);
    put('h48, 32'h00000003);
    put('h4C, 32'hFFFF0060);
    put('h60, 32'h02F101E0);
    put('h64, 32'hBEEF03F5);
    put('h84, 32'h00000002);
    put('h88, 32'h00000042);
    put('h8C, 32'h000000A0);
    put('h90, 32'h00000083);
    put('h94, 32'h000000A8);
    put('hA0, 32'h05F705E6);
    put('hA8, 32'h06F007E1);
    put('hAC, 32'h123407F3);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    base_addr = '0;
    target_id = '0;
    exp_end = 0;
    exp_ng = -1;
    seen_end = 0;
    last_desc_cyc = -1;
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!rd_req && !busy && !done && !error && !desc_valid, "R1 reset outputs",
        {rd_req, busy, done, error, desc_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !busy && !done && !error && !desc_valid, "R1 after reset release",
        {rd_req, busy, done, error, desc_valid}, 0);

    // Single interface, five pins, garbage upper half ignored (R8).
    load_single('h64, 32'h00F300F2);
    run_begin('hE000, 'h80);
    run_wait("single R8");

    // Merged table, second entry matches, two groups (R4, R6).
    load_merged();
    run_begin('h400, 'h80);
    run_wait("merged R4 second");
    run_begin('h400, 'h81);
    run_wait("merged R4 first");

    // No match, zero entry ends search (R5).
    run_begin('h400, 'h55);
    run_wait("nomatch R5");

    // Search bounded by table size (R5, R10).
    clear_mem();
    put('h14, 32'h0000001C);
    put('h18, 32'h11000030);
    put('h1C, 32'h22000030);
    put('h20, 32'h33000030);
    run_begin('h2000, 'h33);
    run_wait("search bound R5");

    // Pointer beyond size (R10).
    clear_mem();
    put('h14, 32'h00000030);
    put('h18, 32'h80000100);
    run_begin('h800, 'h80);
    run_wait("pointer bound R10");

    // Pin list crosses the bound after two descriptors (R10).
    load_single('h58, 32'h00F300F2);
    run_begin('hE000, 'h80);
    run_wait("pin bound R10");

    // Bad type nibble in an upper half (R9).
    load_single('h64, 32'h00A300F2);
    run_begin('hE000, 'h80);
    run_wait("bad type R9");

    // Zero groups: done without descriptors (R11).
    clear_mem();
    put('h14, 32'h00000040);
    put('h18, 32'h80000020);
    put('h24, 32'hFFFFFF00);
    run_begin('h1000, 'h80);
    run_wait("zero groups R11");

    // Zero-pin group followed by a one-pin group (R6, R8).
    clear_mem();
    put('h14, 32'h00000060);
    put('h18, 32'h80000020);
    put('h24, 32'h00000002);
    put('h28, 32'h00000040);
    put('h2C, 32'h00000050);
    put('h30, 32'h00000001);
    put('h34, 32'h00000054);
    put('h54, 32'hBAD009F2);
    run_begin('h1000, 'h80);
    run_wait("zero pin group R6");

    // Start while busy is ignored (R12).
    load_single('h64, 32'h00F300F2);
    run_begin('hE000, 'h80);
    repeat (6) @(negedge clk);
    base_addr = 24'h400;
    target_id = 8'h81;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_wait("start busy R12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule